// File: doc/BRIEF.md
# Receive Frame Classifier and Router

This block takes received Ethernet frames as a byte-wide stream (one byte per accepted beat, with a marker on the final byte) and decides where each frame goes. Frames addressed to the station's own hardware address, or to the all-ones broadcast address, are kept. Every other frame is discarded silently.

A kept frame is steered to one of two byte-wide output streams. The real-time sample receiver gets only the UDP payload, and only from IPv4/UDP datagrams sent to the station's own IP address on the fixed sample port. The host-processor stream gets every other kept frame. On that stream the frame is preceded by its two Ethertype bytes, followed by everything after the 14-byte Ethernet header.

Each frame is held in a local store until its final byte arrives, so the route is settled before any output byte leaves. While a frame is being played out, the input is stalled. A separate counter records how many frames the host side reports as fully consumed. It serves as the acknowledgement to the memory controller.

Top module: `rfc_classifier`

## Requirements
- R1: A frame is kept only when bytes 0..5 equal `local_mac` (most significant byte first) or are all 0xFF. Any other frame produces no output byte on either stream.
- R2: A frame of fewer than 14 bytes produces no output and leaves the block ready for the next frame.
- R3: A host-bound frame of length L appears on the cpu stream as the Ethertype high byte, then the Ethertype low byte (frame bytes 12, 13), then frame bytes 14..L-1. `cpu_last` is set only on the final byte. A 14-byte frame yields exactly the two Ethertype bytes.
- R4: A frame goes to the vita stream when all of these hold:
  - Ethertype is 0x0800.
  - Byte 14 is 0x45.
  - Byte 23 is 17.
  - Bytes 30..33 equal `local_ip` (most significant byte first).
  - Bytes 36..37 equal 1000 (0x03E8).
  - L is at least 43.
  
  The vita stream then carries frame bytes 42..L-1, with `vita_last` on the final byte.
- R5: A kept frame that misses any R4 condition goes to the cpu stream. This includes ARP (0x0806), a header-length byte other than 0x45, another IP protocol, another IP address, another port, and an empty UDP payload.
- R6: A kept frame appears on exactly one stream, and `cpu_valid` and `vita_valid` are never high together.
- R7: `in_ready` drops in the cycle after the last byte of a kept frame is accepted. The first output byte appears one cycle after that last input edge. `in_ready` stays low until the frame's final output byte is presented.
- R8: A frame longer than DEPTH (128) bytes is dropped with no output. A frame of exactly DEPTH bytes is processed normally.
- R9: `done_count` increases by one for every cycle in which `cpu_frame_done` is high, wrapping at 2^CNT_W.
- R10: After reset `in_ready` is high, both valid outputs are low and `done_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Station hardware address |
| local_ip | input | 32 | Station IPv4 address |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Block accepts input bytes |
| vita_valid | output | 1 | Sample-receiver byte present |
| vita_data | output | 8 | Sample-receiver byte |
| vita_last | output | 1 | Final sample-receiver byte of the frame |
| cpu_valid | output | 1 | Host byte present |
| cpu_data | output | 8 | Host byte |
| cpu_last | output | 1 | Final host byte of the frame |
| cpu_frame_done | input | 1 | Host finished removing one frame |
| done_count | output | 16 | Count of consumed frames |

## Verification
On every cycle the assertions check the following:
- The two output streams are never valid together.
- A dropped frame leaves both outputs silent.
- Each stream goes quiet after its last byte.
- Input stays stalled while a frame is mid-playout.
- The store index never passes its depth.
- The done counter steps by one on each report.

The byte content of each stream, the Ethertype prefix and the exact match rules cannot be shown by any single-cycle property. These include the 42-byte header strip, the header-length, protocol, address and port conditions, and the depth and length boundaries. They are shown only by the bench's frame scenarios, which compare whole output streams against frames built independently.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_CPU  = 2'd1,
    RT_VITA = 2'd2
  } route_e;

  // byte offsets inside a frame that the routing decision depends on
  localparam int OFF_ETYPE  = 12;
  localparam int ETH_HDR    = 14;
  localparam int OFF_VERIHL = 14;
  localparam int OFF_PROTO  = 23;
  localparam int OFF_DIP    = 30;
  localparam int OFF_DPORT  = 36;
  localparam int UDP_DATA   = 42;

  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
  localparam logic [7:0]  VERIHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_UDP   = 8'd17;

  // byte i (0 = most significant) of a 48-bit address
  function automatic logic [7:0] mac_byte(input logic [47:0] mac, input int unsigned i);
    return 8'(mac >> (8 * (5 - i)));
  endfunction

  // byte i (0 = most significant) of a 32-bit address
  function automatic logic [7:0] ip_byte(input logic [31:0] ip, input int unsigned i);
    return 8'(ip >> (8 * (3 - i)));
  endfunction

  // final routing decision for one frame
  function automatic route_e classify(input logic too_short, input logic oversize,
                                      input logic dst_ok, input logic udp_hit,
                                      input logic has_payload);
    if (too_short || oversize || !dst_ok) return RT_DROP;
    if (udp_hit && has_payload)           return RT_VITA;
    return RT_CPU;
  endfunction

endpackage

// File: rtl/rfc_frame_buf.sv
module rfc_frame_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rfc_hdr_parse.sv
module rfc_hdr_parse
  import rfc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int IDX_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [7:0]       data,
  input  logic             last,
  input  logic [47:0]      local_mac,
  input  logic [31:0]      local_ip,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic             mac_ok_n,
  output logic             bc_ok_n,
  output logic [15:0]      etype_n,
  output logic             v4_ok_n,
  output logic             udp_n,
  output logic             ip_ok_n,
  output logic [15:0]      dport_n,
  output logic             ovf_n
);

  localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);
  localparam logic [IDX_W-1:0] I_MACEND = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_ET0   = IDX_W'(OFF_ETYPE);
  localparam logic [IDX_W-1:0] I_ET1   = IDX_W'(OFF_ETYPE + 1);
  localparam logic [IDX_W-1:0] I_VIHL  = IDX_W'(OFF_VERIHL);
  localparam logic [IDX_W-1:0] I_PROTO = IDX_W'(OFF_PROTO);
  localparam logic [IDX_W-1:0] I_DIP0  = IDX_W'(OFF_DIP);
  localparam logic [IDX_W-1:0] I_DIP3  = IDX_W'(OFF_DIP + 3);
  localparam logic [IDX_W-1:0] I_DP0   = IDX_W'(OFF_DPORT);
  localparam logic [IDX_W-1:0] I_DP1   = IDX_W'(OFF_DPORT + 1);

  logic        mac_ok, bc_ok, v4_ok, udp, ip_ok, ovf;
  logic [15:0] etype, dport;
  logic        in_mac, in_dip;

  assign in_mac = (idx < I_MACEND);
  assign in_dip = (idx >= I_DIP0) && (idx <= I_DIP3);
  assign wr_en  = beat && (idx < DEPTH_I);

  // field values including the byte currently on the input
  always_comb begin
    mac_ok_n = mac_ok;
    bc_ok_n  = bc_ok;
    etype_n  = etype;
    v4_ok_n  = v4_ok;
    udp_n    = udp;
    ip_ok_n  = ip_ok;
    dport_n  = dport;
    ovf_n    = ovf | (idx == DEPTH_I);
    if (in_mac) begin
      mac_ok_n = mac_ok & (data == mac_byte(local_mac, 32'(idx)));
      bc_ok_n  = bc_ok  & (data == 8'hFF);
    end
    if (idx == I_ET0)   etype_n = {data, etype[7:0]};
    if (idx == I_ET1)   etype_n = {etype[15:8], data};
    if (idx == I_VIHL)  v4_ok_n = (data == VERIHL_PLAIN);
    if (idx == I_PROTO) udp_n   = (data == PROTO_UDP);
    if (in_dip)         ip_ok_n = ip_ok & (data == ip_byte(local_ip, 32'(idx - I_DIP0)));
    if (idx == I_DP0)   dport_n = {data, dport[7:0]};
    if (idx == I_DP1)   dport_n = {dport[15:8], data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (beat && last)) begin
      idx    <= '0;
      mac_ok <= 1'b1;
      bc_ok  <= 1'b1;
      etype  <= '0;
      v4_ok  <= 1'b0;
      udp    <= 1'b0;
      ip_ok  <= 1'b1;
      dport  <= '0;
      ovf    <= 1'b0;
    end else if (beat) begin
      idx    <= (idx == DEPTH_I) ? idx : idx + 1'b1;
      mac_ok <= mac_ok_n;
      bc_ok  <= bc_ok_n;
      etype  <= etype_n;
      v4_ok  <= v4_ok_n;
      udp    <= udp_n;
      ip_ok  <= ip_ok_n;
      dport  <= dport_n;
      ovf    <= ovf_n;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) idx <= DEPTH_I); // R8

endmodule

// File: rtl/rfc_egress.sv
module rfc_egress
  import rfc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int IDX_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  route_e           start_route,
  input  logic [IDX_W-1:0] start_len,
  input  logic [15:0]      start_etype,
  output logic [AW-1:0]    rd_addr,
  input  logic [7:0]       rd_data,
  output logic             busy,
  output logic             vita_valid,
  output logic [7:0]       vita_data,
  output logic             vita_last,
  output logic             cpu_valid,
  output logic [7:0]       cpu_data,
  output logic             cpu_last
);

  localparam logic [IDX_W-1:0] HDR_PTR  = IDX_W'(ETH_HDR);
  localparam logic [IDX_W-1:0] VITA_PTR = IDX_W'(UDP_DATA);

  route_e           route_q;
  logic [IDX_W-1:0] ptr, ptr_n, len_q;
  logic [1:0]       pre, pre_n;
  logic [15:0]      etype_q;
  logic [7:0]       emit_byte;
  logic             emit_last;

  assign rd_addr = ptr[AW-1:0];

  // next byte to present: pending Ethertype prefix first, then stored bytes
  always_comb begin
    emit_byte = rd_data;
    emit_last = (ptr == len_q - 1'b1);
    ptr_n     = ptr + 1'b1;
    pre_n     = pre;
    if (pre == 2'd2) begin
      emit_byte = etype_q[15:8];
      emit_last = 1'b0;
      ptr_n     = ptr;
      pre_n     = 2'd1;
    end else if (pre == 2'd1) begin
      emit_byte = etype_q[7:0];
      emit_last = (ptr == len_q);
      ptr_n     = ptr;
      pre_n     = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      route_q    <= RT_DROP;
      ptr        <= '0;
      len_q      <= '0;
      pre        <= '0;
      etype_q    <= '0;
      vita_valid <= 1'b0;
      vita_data  <= '0;
      vita_last  <= 1'b0;
      cpu_valid  <= 1'b0;
      cpu_data   <= '0;
      cpu_last   <= 1'b0;
    end else begin
      vita_valid <= 1'b0;
      cpu_valid  <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        route_q <= start_route;
        len_q   <= start_len;
        etype_q <= start_etype;
        ptr     <= (start_route == RT_VITA) ? VITA_PTR : HDR_PTR;
        pre     <= (start_route == RT_CPU) ? 2'd2 : 2'd0;
      end else if (busy) begin
        if (route_q == RT_CPU) begin
          cpu_valid <= 1'b1;
          cpu_data  <= emit_byte;
          cpu_last  <= emit_last;
        end else begin
          vita_valid <= 1'b1;
          vita_data  <= emit_byte;
          vita_last  <= emit_last;
        end
        ptr <= ptr_n;
        pre <= pre_n;
        if (emit_last) busy <= 1'b0;
      end
    end
  end

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n) !(cpu_valid && vita_valid)); // R6
  AST_CPU_END: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_last) |=> !cpu_valid); // R3
  AST_VITA_END: assert property (@(posedge clk) disable iff (!rst_n) (vita_valid && vita_last) |=> !vita_valid); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R7

endmodule

// File: rtl/rfc_classifier.sv
module rfc_classifier
  import rfc_pkg::*;
#(
  parameter int          DEPTH     = 128,
  parameter int          CNT_W     = 16,
  parameter logic [15:0] VITA_PORT = 16'd1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      local_mac,
  input  logic [31:0]      local_ip,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             vita_valid,
  output logic [7:0]       vita_data,
  output logic             vita_last,
  output logic             cpu_valid,
  output logic [7:0]       cpu_data,
  output logic             cpu_last,
  input  logic             cpu_frame_done,
  output logic [CNT_W-1:0] done_count
);

  localparam int AW    = $clog2(DEPTH);
  localparam int IDX_W = AW + 1;
  localparam logic [IDX_W-1:0] MIN_IDX  = IDX_W'(ETH_HDR - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(UDP_DATA);

  logic             beat, frame_end, busy, wr_en;
  logic [IDX_W-1:0] idx;
  logic             mac_ok_n, bc_ok_n, v4_ok_n, udp_n, ip_ok_n, ovf_n;
  logic [15:0]      etype_n, dport_n;
  logic             udp_hit;
  route_e           route;
  logic [AW-1:0]    rd_addr;
  logic [7:0]       rd_data;

  assign in_ready  = !busy;
  assign beat      = in_valid && in_ready;
  assign frame_end = beat && in_last;

  rfc_hdr_parse #(.DEPTH(DEPTH)) u_parse (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data), .last(in_last),
    .local_mac(local_mac), .local_ip(local_ip), .idx(idx), .wr_en(wr_en),
    .mac_ok_n(mac_ok_n), .bc_ok_n(bc_ok_n), .etype_n(etype_n), .v4_ok_n(v4_ok_n),
    .udp_n(udp_n), .ip_ok_n(ip_ok_n), .dport_n(dport_n), .ovf_n(ovf_n)
  );

  rfc_frame_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_addr(idx[AW-1:0]), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign udp_hit = (etype_n == ETYPE_IPV4) && v4_ok_n && udp_n && ip_ok_n &&
                   (dport_n == VITA_PORT);

  // idx holds the index of the last byte; length is idx + 1
  assign route = classify(idx < MIN_IDX, ovf_n, mac_ok_n || bc_ok_n, udp_hit,
                          idx >= DATA_IDX);

  rfc_egress #(.DEPTH(DEPTH)) u_egress (
    .clk(clk), .rst_n(rst_n), .start(frame_end && (route != RT_DROP)),
    .start_route(route), .start_len(idx + 1'b1), .start_etype(etype_n),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .vita_valid(vita_valid), .vita_data(vita_data), .vita_last(vita_last),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .cpu_last(cpu_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              done_count <= '0;
    else if (cpu_frame_done) done_count <= done_count + 1'b1;
  end

  AST_CMD_STEP: assert property (@(posedge clk) disable iff (!rst_n) cpu_frame_done |=> done_count == $past(done_count) + 1'b1); // R9
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (frame_end && route == RT_DROP) |=> !(cpu_valid || vita_valid)); // R1
  AST_STALL_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n) ((cpu_valid && !cpu_last) || (vita_valid && !vita_last)) |-> !in_ready); // R7

endmodule

// File: tb/sim_rfc_classifier.sv
module sim_rfc_classifier;

  typedef struct packed {
    logic [1:0]  dst;    // 0 own address, 1 broadcast, 2 foreign
    logic [15:0] etype;
    logic [7:0]  verihl;
    logic [7:0]  proto;
    logic        ipm;
    logic [15:0] port;
    logic [7:0]  plen;   // UDP payload bytes after the 42-byte header block
    logic [1:0]  exp;    // 0 dropped, 1 cpu, 2 vita
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd20, 2'd2, 4'd4},  // R4 basic hit
    '{2'd0, 16'h0806, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd10, 2'd1, 4'd5},  // R5 ARP
    '{2'd1, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd5,  2'd2, 4'd1},  // R1 broadcast kept
    '{2'd2, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd8,  2'd0, 4'd1},  // R1 foreign dropped
    '{2'd0, 16'h0800, 8'h46, 8'd17, 1'b1, 16'd1000, 8'd8,  2'd1, 4'd5},  // R5 options present
    '{2'd0, 16'h0800, 8'h45, 8'd6,  1'b1, 16'd1000, 8'd8,  2'd1, 4'd5},  // R5 not UDP
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b0, 16'd1000, 8'd8,  2'd1, 4'd5},  // R5 other IP
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1001, 8'd8,  2'd1, 4'd5},  // R5 other port
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd0,  2'd1, 4'd5},  // R5 empty payload
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd86, 2'd2, 4'd8},  // R8 exactly DEPTH
    '{2'd0, 16'h0800, 8'h45, 8'd17, 1'b1, 16'd1000, 8'd87, 2'd0, 4'd8},  // R8 one over DEPTH
    '{2'd1, 16'h0806, 8'h00, 8'd0,  1'b0, 16'd0,    8'd3,  2'd1, 4'd3}   // R3 broadcast ARP
  };

  localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;
  localparam logic [31:0] MY_IP  = 32'hC0_A8_00_0A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        vita_valid, vita_last, cpu_valid, cpu_last;
  logic [7:0]  vita_data, cpu_data;
  logic        cpu_frame_done = 1'b0;
  logic [15:0] done_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] fr [256];
  logic [7:0] expb [256];
  int exp_n;
  logic [7:0] cpu_got [256];
  logic [7:0] vita_got [256];
  int cpu_n = 0, vita_n = 0, cpu_lastpos = -1, vita_lastpos = -1;
  int cpu_first = -1, vita_first = -1, both_seen = 0;
  int last_edge = 0;
  logic ready_after = 1'b1;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rfc_classifier u0 (
    .clk(clk), .rst_n(rst_n), .local_mac(MY_MAC), .local_ip(MY_IP),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .vita_valid(vita_valid), .vita_data(vita_data), .vita_last(vita_last),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .cpu_last(cpu_last),
    .cpu_frame_done(cpu_frame_done), .done_count(done_count)
  );

  always @(negedge clk) begin
    if (cpu_valid && vita_valid) both_seen = both_seen + 1;
    if (cpu_valid) begin
      if (cpu_n == 0) cpu_first = cyc;
      if (cpu_last) cpu_lastpos = cpu_n;
      if (cpu_n < 256) cpu_got[cpu_n] = cpu_data;
      cpu_n = cpu_n + 1;
    end
    if (vita_valid) begin
      if (vita_n == 0) vita_first = cyc;
      if (vita_last) vita_lastpos = vita_n;
      if (vita_n < 256) vita_got[vita_n] = vita_data;
      vita_n = vita_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic clear_mon();
    cpu_n = 0; vita_n = 0; cpu_lastpos = -1; vita_lastpos = -1;
    cpu_first = -1; vita_first = -1; both_seen = 0;
  endtask

  task automatic build(input vec_t v, input int vi, output int len);
    len = 42 + int'(v.plen);
    for (int i = 0; i < 256; i++) fr[i] = 8'(i * 3 + vi);
    for (int i = 0; i < 6; i++)
      fr[i] = (v.dst == 2'd0) ? MY_MAC[47 - 8*i -: 8] : (v.dst == 2'd1) ? 8'hFF : 8'(8'h60 + i);
    fr[12] = v.etype[15:8];  fr[13] = v.etype[7:0];
    fr[14] = v.verihl;       fr[23] = v.proto;
    for (int i = 0; i < 4; i++)
      fr[30 + i] = v.ipm ? MY_IP[31 - 8*i -: 8] : 8'(8'h70 + i);
    fr[36] = v.port[15:8];   fr[37] = v.port[7:0];
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == n - 1);
    end
    @(negedge clk);
    last_edge = cyc;
    ready_after = in_ready;
    in_valid = 1'b0; in_last = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // route: 0 dropped, 1 cpu, 2 vita
  task automatic verify(input string req, input int route, input int len);
    int mism;
    exp_n = 0;
    if (route == 1) begin
      expb[0] = fr[12]; expb[1] = fr[13]; exp_n = 2;
      for (int i = 14; i < len; i++) begin expb[exp_n] = fr[i]; exp_n++; end
    end else if (route == 2) begin
      for (int i = 42; i < len; i++) begin expb[exp_n] = fr[i]; exp_n++; end
    end
    mism = 0;
    if (route == 1) begin
      for (int i = 0; i < exp_n && i < cpu_n; i++) if (cpu_got[i] !== expb[i]) mism++;
      chk(cpu_n == exp_n, req, "cpu byte count", cpu_n, exp_n);
      chk(vita_n == 0, "R6", "vita bytes on cpu frame", vita_n, 0);
      chk(cpu_lastpos == exp_n - 1, req, "cpu last position", cpu_lastpos, exp_n - 1);
      chk(mism == 0, req, "cpu byte mismatches", mism, 0);
      chk(cpu_first == last_edge + 1, "R7", "first output cycle", cpu_first, last_edge + 1);
    end else if (route == 2) begin
      for (int i = 0; i < exp_n && i < vita_n; i++) if (vita_got[i] !== expb[i]) mism++;
      chk(vita_n == exp_n, req, "vita byte count", vita_n, exp_n);
      chk(cpu_n == 0, "R6", "cpu bytes on vita frame", cpu_n, 0);
      chk(vita_lastpos == exp_n - 1, req, "vita last position", vita_lastpos, exp_n - 1);
      chk(mism == 0, req, "vita byte mismatches", mism, 0);
      chk(vita_first == last_edge + 1, "R7", "first output cycle", vita_first, last_edge + 1);
    end else begin
      chk(cpu_n + vita_n == 0, req, "bytes from dropped frame", cpu_n + vita_n, 0);
      chk(ready_after == 1'b1, req, "in_ready after dropped frame", int'(ready_after), 1);
    end
    if (route != 0)
      chk(ready_after == 1'b0, "R7", "in_ready after kept frame", int'(ready_after), 0);
    chk(both_seen == 0, "R6", "both streams valid", both_seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
    chk(!cpu_valid && !vita_valid, "R10", "valids in reset", int'(cpu_valid | vita_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_count == 16'd0, "R10", "done_count after reset", int'(done_count), 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[v].req);
      build(VECS[v], v, len);
      clear_mon();
      send(len);
      verify(tag, int'(VECS[v].exp), len);
    end

    // R2 frames cut short before the Ethertype is complete
    build(VECS[0], 20, len);
    clear_mon(); send(10);
    verify("R2", 0, 10);
    clear_mon(); send(13);
    verify("R2", 0, 13);

    // R3 minimum frame: header only, own address, private Ethertype
    build(VECS[0], 21, len);
    fr[12] = 8'h88; fr[13] = 8'hB5;
    clear_mon(); send(14);
    verify("R3", 1, 14);

    // R1 a foreign frame after a kept one must still be dropped
    build(VECS[3], 22, len);
    clear_mon(); send(len);
    verify("R1", 0, len);

    // R9 consumed-frame counter
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) cpu_frame_done = 1'b1;
      @(negedge clk) cpu_frame_done = 1'b0;
    end
    @(negedge clk);
    chk(done_count == 16'd3, "R9", "done_count after three reports", int'(done_count), 3);
    @(negedge clk) cpu_frame_done = 1'b1;
    repeat (2) @(negedge clk);
    cpu_frame_done = 1'b0;
    @(negedge clk);
    chk(done_count == 16'd5, "R9", "done_count after held report", int'(done_count), 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule